// File: doc/BRIEF.md
# Serial Audio Port Sample FIFO Pair

This block holds two byte-addressed sample queues for a serial audio port. The playback queue is filled from the register side and emptied by the serial shifter. The capture queue is filled by the shifter and emptied from the register side. Each queue has a capacity of `DEPTH` bytes (128 by default). It keeps its own run control, entry size, threshold, sticky error flags and packed status word.

Software brings a queue up in a fixed order. It asserts the queue's clear bit, drops it, then sets the run bit before it enables the serial side. To stop, it disables the serial side first and then drops the run bit. Each push or pop moves one entry of 1, 2 or 4 bytes, as set by the entry-size code. The level is always counted in bytes. While the playback queue cannot supply a full entry, its output data reads as zero, so the port plays silence rather than stale samples.

Top module: `audio_fifo_pair`

## Requirements
- R1: While a queue's clear input is high, at the next edge its level becomes 0 and its overflow and underflow flags drop, so its status reads 0x100. Clear takes priority over run and over any push or pop in the same cycle.
- R2: While run is low and clear is low, pushes and pops are ignored. The status word, the overflow flag and the underflow flag keep their values.
- R3: The entry-size code selects the bytes per entry: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. An accepted push adds that many bytes to the level, and an accepted pop subtracts them. An accepted push and an accepted pop in the same cycle leave the level unchanged.
- R4: A push stores the low bytes of its 32-bit data, least significant byte first. A pop returns the oldest bytes with the first stored byte in bits 7:0 and zeros above the entry. First-in, first-out order is kept across every entry size.
- R5: The status word holds the level modulo the capacity in bits 6:0, full (level equal to capacity) in bit 7, and empty (level 0) in bit 8.
- R6: A push that does not fit in the free space is dropped and sets the sticky overflow flag. Acceptance is judged on the level before the edge, so a pop in the same cycle does not make room.
- R7: A pop while fewer bytes are held than one entry is dropped and sets the sticky underflow flag. In that state the pop data output is zero.
- R8: The playback threshold flag is high when the level is at or below the threshold input. The capture threshold flag is high when the level is at or above its threshold input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_op_rst | input | 1 | Playback queue clear |
| tx_op_start | input | 1 | Playback queue run |
| tx_width | input | 2 | Playback entry-size code |
| tx_thresh | input | 7 | Playback threshold in bytes |
| tx_push | input | 1 | Register-side write strobe |
| tx_push_data | input | 32 | Register-side write data |
| tx_pop | input | 1 | Shifter-side read strobe |
| tx_pop_data | output | 32 | Oldest entry, zero when not enough bytes |
| tx_status | output | 9 | Playback packed status |
| tx_thr | output | 1 | Playback threshold flag |
| tx_ovf | output | 1 | Playback sticky overflow |
| tx_udf | output | 1 | Playback sticky underflow |
| rx_op_rst | input | 1 | Capture queue clear |
| rx_op_start | input | 1 | Capture queue run |
| rx_width | input | 2 | Capture entry-size code |
| rx_thresh | input | 7 | Capture threshold in bytes |
| rx_push | input | 1 | Shifter-side write strobe |
| rx_push_data | input | 32 | Shifter-side write data |
| rx_pop | input | 1 | Register-side read strobe |
| rx_pop_data | output | 32 | Oldest entry, zero when not enough bytes |
| rx_status | output | 9 | Capture packed status |
| rx_thr | output | 1 | Capture threshold flag |
| rx_ovf | output | 1 | Capture sticky overflow |
| rx_udf | output | 1 | Capture sticky underflow |

## Verification
Both queues get the same stimulus in every cycle. For each entry size they are filled one entry at a time past capacity and then drained past empty. This separates byte counting from entry counting, and the wrap of the level field at full from a true zero level. Several threshold values, including the extremes, are applied during these sweeps. This tells the playback comparison (at or below) apart from the capture comparison (at or above), and exposes off-by-one errors at the boundary. Further cases cover clear asserted together with run and push, strobes while stopped, and a push and a pop in the same cycle at both a full and a part-full level. These show clear priority, strobe gating, and acceptance decided on the level before the edge.

// File: rtl/audio_fifo_pair.sv
`timescale 1ns/1ps
module audio_fifo_pair #(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_op_rst,
  input  logic        tx_op_start,
  input  logic [1:0]  tx_width,
  input  logic [$clog2(DEPTH)-1:0] tx_thresh,
  input  logic        tx_push,
  input  logic [31:0] tx_push_data,
  input  logic        tx_pop,
  output logic [31:0] tx_pop_data,
  output logic [$clog2(DEPTH)+1:0] tx_status,
  output logic        tx_thr,
  output logic        tx_ovf,
  output logic        tx_udf,
  input  logic        rx_op_rst,
  input  logic        rx_op_start,
  input  logic [1:0]  rx_width,
  input  logic [$clog2(DEPTH)-1:0] rx_thresh,
  input  logic        rx_push,
  input  logic [31:0] rx_push_data,
  input  logic        rx_pop,
  output logic [31:0] rx_pop_data,
  output logic [$clog2(DEPTH)+1:0] rx_status,
  output logic        rx_thr,
  output logic        rx_ovf,
  output logic        rx_udf
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam logic [LW:0] CAP = (LW+1)'(DEPTH);

  logic [1:0]         clr, go, psh, pp, thr_f, ovf_f, udf_f;
  logic [1:0][1:0]    wid;
  logic [1:0][PW-1:0] thr;
  logic [1:0][31:0]   pdat, qdat;
  logic [1:0][PW+1:0] st;

  assign clr  = {rx_op_rst, tx_op_rst};
  assign go   = {rx_op_start, tx_op_start};
  assign psh  = {rx_push, tx_push};
  assign pp   = {rx_pop, tx_pop};
  assign wid  = {rx_width, tx_width};
  assign thr  = {rx_thresh, tx_thresh};
  assign pdat = {rx_push_data, tx_push_data};

  assign tx_pop_data = qdat[0];
  assign rx_pop_data = qdat[1];
  assign tx_status   = st[0];
  assign rx_status   = st[1];
  assign tx_thr      = thr_f[0];
  assign rx_thr      = thr_f[1];
  assign tx_ovf      = ovf_f[0];
  assign rx_ovf      = ovf_f[1];
  assign tx_udf      = udf_f[0];
  assign rx_udf      = udf_f[1];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] level, n;
    logic          okp, okq, ovf_q, udf_q;
    logic [31:0]   head;

    always_comb begin
      case (wid[c])
        2'd0:    n = LW'(1);
        2'd1:    n = LW'(2);
        default: n = LW'(4);
      endcase
    end

    assign okp = go[c] && psh[c] && (({1'b0, level} + {1'b0, n}) <= CAP);
    assign okq = go[c] && pp[c] && (level >= n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; level <= '0; ovf_q <= 1'b0; udf_q <= 1'b0;
      end else if (clr[c]) begin
        wp <= '0; rp <= '0; level <= '0; ovf_q <= 1'b0; udf_q <= 1'b0;
      end else if (go[c]) begin
        if (okp) wp <= wp + n[PW-1:0];
        if (okq) rp <= rp + n[PW-1:0];
        level <= level + (okp ? n : '0) - (okq ? n : '0);
        if (psh[c] && !okp) ovf_q <= 1'b1;
        if (pp[c] && !okq)  udf_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (okp && !clr[c])
        for (int k = 0; k < 4; k++)
          if (LW'(k) < n) mem[PW'(wp + PW'(k))] <= pdat[c][8*k +: 8];
    end

    always_comb begin
      head = '0;
      for (int k = 0; k < 4; k++)
        if (LW'(k) < n) head[8*k +: 8] = mem[PW'(rp + PW'(k))];
    end

    assign qdat[c]  = (level >= n) ? head : 32'd0;
    assign st[c]    = {level == '0, level[PW], level[PW-1:0]};
    assign ovf_f[c] = ovf_q;
    assign udf_f[c] = udf_q;

    if (c == 0) begin : g_low
      assign thr_f[c] = level <= {1'b0, thr[c]};
    end else begin : g_high
      assign thr_f[c] = level >= {1'b0, thr[c]};
    end
  end
endmodule

module audio_fifo_pair_chk #(
  parameter int DEPTH = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_op_rst,
  input logic        tx_op_start,
  input logic [$clog2(DEPTH)-1:0] tx_thresh,
  input logic [31:0] tx_pop_data,
  input logic [$clog2(DEPTH)+1:0] tx_status,
  input logic        tx_thr,
  input logic        tx_ovf,
  input logic        tx_udf,
  input logic        rx_op_rst,
  input logic [$clog2(DEPTH)-1:0] rx_thresh,
  input logic [$clog2(DEPTH)+1:0] rx_status,
  input logic        rx_thr,
  input logic        rx_ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [LW-1:0] lv_tx, lv_rx, prev_tx, up, dn;
  assign lv_tx = tx_status[PW] ? LW'(DEPTH) : {1'b0, tx_status[PW-1:0]};
  assign lv_rx = rx_status[PW] ? LW'(DEPTH) : {1'b0, rx_status[PW-1:0]};
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_tx <= '0; else prev_tx <= lv_tx;
  assign up = lv_tx - prev_tx;
  assign dn = prev_tx - lv_tx;

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_op_rst |=> (lv_tx == '0) && tx_status[PW+1] && !tx_ovf && !tx_udf);
  p_clear_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_op_rst |=> (lv_rx == '0) && !rx_ovf);
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_op_rst && !tx_op_start) |=> $stable(tx_status) && $stable(tx_ovf) && $stable(tx_udf));
  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_op_rst && tx_op_start) |=> (up inside {LW'(0), LW'(1), LW'(2), LW'(4)}) ||
                                    (dn inside {LW'(1), LW'(2), LW'(4)}));
  p_full_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_status[PW] && tx_status[PW+1]));
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_op_rst) |=> tx_ovf);
  p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_udf && !tx_op_rst) |=> tx_udf);
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_status[PW+1] |-> (tx_pop_data == 32'd0));
  p_tx_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_thr |-> (lv_tx <= {1'b0, tx_thresh}));
  p_rx_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_thr |-> (lv_rx >= {1'b0, rx_thresh}));
endmodule

bind audio_fifo_pair audio_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_op_rst(tx_op_rst), .tx_op_start(tx_op_start),
  .tx_thresh(tx_thresh), .tx_pop_data(tx_pop_data), .tx_status(tx_status),
  .tx_thr(tx_thr), .tx_ovf(tx_ovf), .tx_udf(tx_udf), .rx_op_rst(rx_op_rst),
  .rx_thresh(rx_thresh), .rx_status(rx_status), .rx_thr(rx_thr), .rx_ovf(rx_ovf)
);

// File: tb/audio_fifo_pair_bench.sv
`timescale 1ns/1ps
module audio_fifo_pair_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_rst = 1'b0, op_go = 1'b0, ps = 1'b0, pp = 1'b0;
  logic [1:0]  w = 2'd0;
  logic [6:0]  th = 7'd0;
  logic [31:0] d = 32'd0;
  logic [31:0] tx_q, rx_q;
  logic [8:0]  tx_st, rx_st;
  logic tx_thr, rx_thr, tx_ovf, rx_ovf, tx_udf, rx_udf;

  int total = 0, fails = 0;
  int lvl = 0;
  bit e_ovf = 0, e_udf = 0;
  byte unsigned q[$];

  always #(PERIOD/2) clk = ~clk;

  audio_fifo_pair #(.DEPTH(DEPTH)) u_audio_fifo_pair (
    .clk(clk), .rst_n(rst_n),
    .tx_op_rst(op_rst), .tx_op_start(op_go), .tx_width(w), .tx_thresh(th),
    .tx_push(ps), .tx_push_data(d), .tx_pop(pp), .tx_pop_data(tx_q),
    .tx_status(tx_st), .tx_thr(tx_thr), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
    .rx_op_rst(op_rst), .rx_op_start(op_go), .rx_width(w), .rx_thresh(th),
    .rx_push(ps), .rx_push_data(d), .rx_pop(pp), .rx_pop_data(rx_q),
    .rx_status(rx_st), .rx_thr(rx_thr), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nb();
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [8:0] stword(input int l);
    return {l == 0, l == DEPTH, 7'(l % DEPTH)};
  endfunction

  task automatic check_all(input string req);
    chk(req, 32'(tx_st), 32'(stword(lvl)));
    chk(req, 32'(rx_st), 32'(stword(lvl)));
    chk("R6", 32'(tx_ovf), 32'(e_ovf));
    chk("R6", 32'(rx_ovf), 32'(e_ovf));
    chk("R7", 32'(tx_udf), 32'(e_udf));
    chk("R7", 32'(rx_udf), 32'(e_udf));
    chk("R8", 32'(tx_thr), 32'(lvl <= int'(th)));
    chk("R8", 32'(rx_thr), 32'(lvl >= int'(th)));
  endtask

  task automatic cyc(input bit p_in, input bit q_in, input logic [31:0] din, input string req);
    int n = nb();
    bit okp, okq;
    logic [31:0] exp_q = 32'd0;
    okp = op_go && p_in && (lvl + n <= DEPTH);
    okq = op_go && q_in && (lvl >= n);
    if (lvl >= n)
      for (int k = 0; k < n; k++) exp_q[8*k +: 8] = q[k];
    if (q_in) begin
      chk((lvl >= n) ? "R4" : "R7", tx_q, exp_q);
      chk((lvl >= n) ? "R4" : "R7", rx_q, exp_q);
    end
    ps = p_in; pp = q_in; d = din;
    @(posedge clk); #1;
    ps = 1'b0; pp = 1'b0;
    if (op_rst) begin
      lvl = 0; e_ovf = 0; e_udf = 0; q.delete();
    end else if (op_go) begin
      if (okq) begin
        for (int k = 0; k < n; k++) void'(q.pop_front());
        lvl -= n;
      end
      if (okp) begin
        for (int k = 0; k < n; k++) q.push_back(din[8*k +: 8]);
        lvl += n;
      end
      if (p_in && !okp) e_ovf = 1;
      if (q_in && !okq) e_udf = 1;
    end
    check_all(req);
  endtask

  task automatic clear_and_run();
    op_rst = 1'b1; op_go = 1'b1;
    cyc(1'b1, 1'b1, 32'hDEADBEEF, "R1");
    chk("R1", 32'(tx_st), 32'h100);
    op_rst = 1'b0;
    cyc(1'b0, 1'b0, 32'd0, "R1");
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(tx_st), 32'h100);
    chk("R1", 32'(rx_st), 32'h100);
    chk("R7", tx_q, 32'd0);
    rst_n = 1'b1;
    for (int wi = 0; wi < 3; wi++) begin
      for (int ti = 0; ti < 3; ti++) begin
        w  = 2'(wi);
        th = (ti == 0) ? 7'd0 : (ti == 1) ? 7'(17 + 9 * wi) : 7'd127;
        clear_and_run();
        for (int i = 0; i <= DEPTH / nb(); i++)
          cyc(1'b1, 1'b0, 32'h01020304 * (i + 1) + 32'(wi * 37), "R3");
        chk("R5", 32'(tx_st), 32'h080);
        chk("R6", 32'(tx_ovf), 32'd1);
        cyc(1'b1, 1'b1, 32'hA5A5A5A5, "R6");
        op_go = 1'b0;
        cyc(1'b1, 1'b1, 32'h11111111, "R2");
        cyc(1'b0, 1'b1, 32'h0, "R2");
        op_go = 1'b1;
        while (lvl >= nb()) cyc(1'b0, 1'b1, 32'h0, "R3");
        cyc(1'b0, 1'b1, 32'h0, "R7");
        chk("R7", tx_q, 32'd0);
        chk("R5", 32'(tx_st), 32'h100);
      end
      clear_and_run();
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 32'hC0FFEE00 + 32'(i), "R3");
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 32'h5A000000 + 32'(i * 3), "R3");
      while (lvl >= nb()) cyc(1'b0, 1'b1, 32'h0, "R4");
    end
    w = 2'd3; th = 7'd8;
    clear_and_run();
    cyc(1'b1, 1'b0, 32'h87654321, "R3");
    chk("R3", 32'(tx_st), 32'h004);
    cyc(1'b0, 1'b1, 32'h0, "R4");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule